// File: doc/BRIEF.md
# Overlap-Safe Rectangle Blit Engine

This block moves a rectangle of pixels from one place to another inside a linear frame buffer, or paints a rectangle with a solid colour. The buffer's row pitch in bytes (`stride`) and the pixel size in bytes (`bpp`) are set by plain inputs. Both the source and the destination rectangle are range-checked before any memory traffic. An accepted operation is broken into one memory-move descriptor per row. Each descriptor asks the memory side to read a burst from one address and write it to another, or to write a replicated colour. For a copy, the order of the rows is chosen so that a source and destination that overlap still give a correct result.

Each accepted operation ends by recording its destination rectangle in a power-of-two ring of dirty regions. A display refresh path drains this ring. A single invalidate pulse drops every region still held. Commands enter on a valid/ready stream. The block takes a new command only when it is idle, so `cmd_ready` low is the block's back-pressure. Move descriptors leave on a valid/ready stream. A descriptor is held unchanged until the memory side raises `mv_ready`. Dirty regions leave on a third valid/ready stream and stay at the head of the ring until `dr_ready` is seen.

Top module: `rect_blit_engine`

## Requirements
- R1: A rectangle with a negative x, y, width or height (two's complement fields) is rejected.
- R2: A rectangle is rejected when x or width exceeds MAX_W (default 2368) or when y or height exceeds MAX_H (default 1770); values equal to the limit are allowed.
- R3: A rectangle is rejected when x+width exceeds `surf_w` or y+height exceeds `surf_h`. A copy checks source and destination separately. A fill (`cmd_fill`=1) checks only the destination and ignores the source fields.
- R4: A rejected operation raises `done_pulse` with `done_err`=1, issues no descriptor and adds no dirty region.
- R5: Every descriptor addresses a row start at bpp*x + stride*row and has `mv_len` = bpp*width bytes. A copy issues exactly one descriptor per row.
- R6: When the destination y is greater than the source y, copy rows are issued from the last row to the first, with the addresses stepping down by `stride`. Otherwise rows are issued from the first to the last, stepping up by `stride`.
- R7: A fill first issues a descriptor with `mv_fill`=1 for the top destination row, carrying `mv_colour`. Each following row is a plain copy (`mv_fill`=0) whose source is the top row, issued in ascending order.
- R8: While `mv_valid` is high and `mv_ready` is low, every descriptor field is held and `mv_valid` stays high.
- R9: `done_pulse` is high for exactly one cycle, in the cycle after the last descriptor is accepted. `cmd_ready` is high only while the block is idle.
- R10: Every accepted operation appends its destination (x, y, width, height) to the dirty ring, and the ring presents these regions on `dr_*` oldest first.
- R11: A region appended to a full ring overwrites the oldest region, so the ring keeps the RING_DEPTH newest regions.
- R12: An `invalidate` pulse empties the ring, so `dr_valid` is low in the next cycle unless a region is appended in that same cycle.
- R13: An accepted operation of zero width or zero height issues no descriptor but still completes without error and appends its region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| surf_w | input | COORD_W | Surface width in pixels |
| surf_h | input | COORD_W | Surface height in rows |
| stride | input | ADDR_W | Row pitch in bytes |
| bpp | input | 3 | Bytes per pixel (1 to 4) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this edge |
| cmd_fill | input | 1 | 1 = solid fill, 0 = copy |
| cmd_sx | input | COORD_W | Source x (signed) |
| cmd_sy | input | COORD_W | Source y (signed) |
| cmd_dx | input | COORD_W | Destination x (signed) |
| cmd_dy | input | COORD_W | Destination y (signed) |
| cmd_w | input | COORD_W | Width in pixels (signed) |
| cmd_h | input | COORD_W | Height in rows (signed) |
| cmd_colour | input | 32 | Fill colour, low bpp bytes used, little-endian |
| mv_valid | output | 1 | Row descriptor offered |
| mv_ready | input | 1 | Memory side accepts the descriptor |
| mv_fill | output | 1 | 1 = write replicated colour, 0 = copy from mv_src |
| mv_src | output | ADDR_W | Source byte address of the row |
| mv_dst | output | ADDR_W | Destination byte address of the row |
| mv_len | output | COORD_W+3 | Bytes in the row |
| mv_colour | output | 32 | Colour for a fill descriptor |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_err | output | 1 | Completion was a rejection (valid with done_pulse) |
| invalidate | input | 1 | Drop all queued dirty regions |
| dr_valid | output | 1 | Dirty region available |
| dr_ready | input | 1 | Consumer takes the dirty region |
| dr_x | output | COORD_W | Dirty region x |
| dr_y | output | COORD_W | Dirty region y |
| dr_w | output | COORD_W | Dirty region width |
| dr_h | output | COORD_W | Dirty region height |

## Verification
A wrong row direction or address step shows up in the first descriptor of the operation. Its destination address is not the expected row, and the frame-buffer contents after an overlapping copy differ from a copy of the untouched source. A faulty range check shows up at the completion strobe, a few cycles after the command is taken: the error flag is wrong, or descriptors appear when none should. Ring pointer faults appear at the next drain, as a missing, duplicated or stale region on `dr_*`.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/rect_check.sv
module rect_check #(
  parameter int COORD_W = 16,
  parameter int MAX_W   = 2368,
  parameter int MAX_H   = 1770
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] w,
  input  logic [COORD_W-1:0] h,
  input  logic [COORD_W-1:0] surf_w,
  input  logic [COORD_W-1:0] surf_h,
  output logic               bad
);

  localparam int EW = COORD_W + 1;
  localparam logic signed [EW-1:0] LIM_W = EW'(MAX_W);
  localparam logic signed [EW-1:0] LIM_H = EW'(MAX_H);

  logic signed [EW-1:0] xe, ye, we, he, end_x, end_y, sw, sh;
  logic neg_any, over_lim, over_surf;

  always_comb begin
    xe    = {x[COORD_W-1], x};
    ye    = {y[COORD_W-1], y};
    we    = {w[COORD_W-1], w};
    he    = {h[COORD_W-1], h};
    sw    = {1'b0, surf_w};
    sh    = {1'b0, surf_h};
    end_x = xe + we;
    end_y = ye + he;
    neg_any   = x[COORD_W-1] | y[COORD_W-1] | w[COORD_W-1] | h[COORD_W-1];
    over_lim  = (xe > LIM_W) | (we > LIM_W) | (ye > LIM_H) | (he > LIM_H);
    over_surf = (end_x > sw) | (end_y > sh);
    bad       = neg_any | over_lim | over_surf;
  end

endmodule

// File: rtl/dirty_ring.sv
module dirty_ring #(
  parameter int DEPTH   = 512,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               invalidate,
  output logic               pop_valid,
  input  logic               pop_ready,
  output logic [ENTRY_W-1:0] pop_data
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [IDX_W-1:0]   head_q, tail_q;
  logic [CNT_W-1:0]   count_q;
  logic               full, do_pop;

  assign full      = (count_q == FULL_CNT);
  assign pop_valid = (count_q != '0);
  assign do_pop    = pop_valid && pop_ready;
  assign pop_data  = slots[head_q];

  always_ff @(posedge clk) begin
    if (push) slots[tail_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (invalidate) begin
      head_q  <= tail_q;
      count_q <= push ? CNT_W'(1) : '0;
      if (push) tail_q <= tail_q + IDX_W'(1);
    end else begin
      if (push) tail_q <= tail_q + IDX_W'(1);
      if (do_pop || (push && full)) head_q <= head_q + IDX_W'(1);
      if (push && !do_pop && !full)
        count_q <= count_q + CNT_W'(1);
      else if (do_pop && !push)
        count_q <= count_q - CNT_W'(1);
    end
  end

  AST_FULL_PUSH_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !invalidate && !do_pop) |=> (full && pop_valid)); // R11

  AST_INVALIDATE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidate && !push) |=> !pop_valid); // R12

endmodule

// File: rtl/blit_sequencer.sv
module blit_sequencer
  import blit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = COORD_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [2:0]         bpp,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_fill,
  input  logic [COORD_W-1:0] cmd_sx,
  input  logic [COORD_W-1:0] cmd_sy,
  input  logic [COORD_W-1:0] cmd_dx,
  input  logic [COORD_W-1:0] cmd_dy,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  input  logic [31:0]        cmd_colour,
  output logic [COORD_W-1:0] lat_sx,
  output logic [COORD_W-1:0] lat_sy,
  output logic [COORD_W-1:0] lat_dx,
  output logic [COORD_W-1:0] lat_dy,
  output logic [COORD_W-1:0] lat_w,
  output logic [COORD_W-1:0] lat_h,
  input  logic               bad_src,
  input  logic               bad_dst,
  output logic               mv_valid,
  input  logic               mv_ready,
  output logic               mv_fill,
  output logic [ADDR_W-1:0]  mv_src,
  output logic [ADDR_W-1:0]  mv_dst,
  output logic [LEN_W-1:0]   mv_len,
  output logic [31:0]        mv_colour,
  output logic               done_pulse,
  output logic               done_err,
  output logic               push_valid
);

  localparam logic signed [COORD_W-1:0] ONE_S = COORD_W'(1);
  localparam logic [COORD_W-1:0]        ONE_U = COORD_W'(1);

  seq_state_e state_q;

  logic                      fill_q, err_q, up_q, first_q;
  logic signed [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q;
  logic [31:0]               col_q;
  logic [COORD_W-1:0]        rows_q;
  logic [ADDR_W-1:0]         src_q, dst_q;
  logic [LEN_W-1:0]          len_q;

  logic                      reject, go_up, zero_area, last_row;
  logic signed [COORD_W-1:0] src_row, dst_row;
  logic [ADDR_W-1:0]         src_start, dst_start;
  logic [ADDR_W-1:0]         step_src, step_dst;

  always_comb begin
    reject    = bad_dst | (!fill_q & bad_src);
    go_up     = !fill_q && (dy_q > sy_q);
    zero_area = (w_q == '0) || (h_q == '0);
    src_row   = go_up ? (sy_q + h_q - ONE_S) : sy_q;
    dst_row   = go_up ? (dy_q + h_q - ONE_S) : dy_q;
    src_start = ADDR_W'(bpp) * ADDR_W'(sx_q) + stride * ADDR_W'(src_row);
    dst_start = ADDR_W'(bpp) * ADDR_W'(dx_q) + stride * ADDR_W'(dst_row);
    last_row  = (rows_q == ONE_U);
    if (fill_q) begin
      step_src = src_q;
      step_dst = dst_q + stride;
    end else if (up_q) begin
      step_src = src_q - stride;
      step_dst = dst_q - stride;
    end else begin
      step_src = src_q + stride;
      step_dst = dst_q + stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fill_q  <= 1'b0;
      err_q   <= 1'b0;
      up_q    <= 1'b0;
      first_q <= 1'b0;
      sx_q    <= '0;
      sy_q    <= '0;
      dx_q    <= '0;
      dy_q    <= '0;
      w_q     <= '0;
      h_q     <= '0;
      col_q   <= '0;
      rows_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          fill_q  <= cmd_fill;
          sx_q    <= cmd_sx;
          sy_q    <= cmd_sy;
          dx_q    <= cmd_dx;
          dy_q    <= cmd_dy;
          w_q     <= cmd_w;
          h_q     <= cmd_h;
          col_q   <= cmd_colour;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          err_q   <= reject;
          up_q    <= go_up;
          first_q <= 1'b1;
          rows_q  <= h_q;
          src_q   <= fill_q ? dst_start : src_start;
          dst_q   <= dst_start;
          len_q   <= LEN_W'(bpp) * LEN_W'(w_q);
          state_q <= (reject || zero_area) ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE: if (mv_ready) begin
          if (last_row) begin
            state_q <= ST_DONE;
          end else begin
            rows_q  <= rows_q - ONE_U;
            first_q <= 1'b0;
            src_q   <= step_src;
            dst_q   <= step_dst;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign mv_valid   = (state_q == ST_ISSUE);
  assign mv_fill    = fill_q && first_q;
  assign mv_src     = src_q;
  assign mv_dst     = dst_q;
  assign mv_len     = len_q;
  assign mv_colour  = col_q;
  assign done_pulse = (state_q == ST_DONE);
  assign done_err   = err_q;
  assign push_valid = (state_q == ST_DONE) && !err_q;

  assign lat_sx = sx_q;
  assign lat_sy = sy_q;
  assign lat_dx = dx_q;
  assign lat_dy = dy_q;
  assign lat_w  = w_q;
  assign lat_h  = h_q;

  AST_MV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_src) && $stable(mv_dst)
                                 && $stable(mv_len) && $stable(mv_fill))); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && last_row) |=> (done_pulse && !done_err)); // R9

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHECK) && reject) |=> (done_pulse && done_err && !mv_valid)); // R4

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && !last_row && !fill_q) |=>
      (mv_dst == (up_q ? $past(mv_dst) - $past(stride) : $past(mv_dst) + $past(stride)))); // R6

  AST_FILL_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && !last_row && fill_q) |=>
      (!mv_fill && mv_src == $past(mv_src))); // R7

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine #(
  parameter int COORD_W    = 16,
  parameter int ADDR_W     = 32,
  parameter int MAX_W      = 2368,
  parameter int MAX_H      = 1770,
  parameter int RING_DEPTH = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] surf_w,
  input  logic [COORD_W-1:0] surf_h,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [2:0]         bpp,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_fill,
  input  logic [COORD_W-1:0] cmd_sx,
  input  logic [COORD_W-1:0] cmd_sy,
  input  logic [COORD_W-1:0] cmd_dx,
  input  logic [COORD_W-1:0] cmd_dy,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  input  logic [31:0]        cmd_colour,
  output logic               mv_valid,
  input  logic               mv_ready,
  output logic               mv_fill,
  output logic [ADDR_W-1:0]  mv_src,
  output logic [ADDR_W-1:0]  mv_dst,
  output logic [COORD_W+2:0] mv_len,
  output logic [31:0]        mv_colour,
  output logic               done_pulse,
  output logic               done_err,
  input  logic               invalidate,
  output logic               dr_valid,
  input  logic               dr_ready,
  output logic [COORD_W-1:0] dr_x,
  output logic [COORD_W-1:0] dr_y,
  output logic [COORD_W-1:0] dr_w,
  output logic [COORD_W-1:0] dr_h
);

  localparam int LEN_W   = COORD_W + 3;
  localparam int ENTRY_W = 4 * COORD_W;
  localparam int N_CHK   = 2;

  logic [COORD_W-1:0] lat_sx, lat_sy, lat_dx, lat_dy, lat_w, lat_h;
  logic [COORD_W-1:0] chk_x [N_CHK];
  logic [COORD_W-1:0] chk_y [N_CHK];
  logic [N_CHK-1:0]   chk_bad;
  logic               push_valid;
  logic [ENTRY_W-1:0] ring_out;

  assign chk_x[0] = lat_sx;
  assign chk_y[0] = lat_sy;
  assign chk_x[1] = lat_dx;
  assign chk_y[1] = lat_dy;

  for (genvar gi = 0; gi < N_CHK; gi++) begin : g_chk
    rect_check #(
      .COORD_W(COORD_W),
      .MAX_W  (MAX_W),
      .MAX_H  (MAX_H)
    ) u_chk (
      .x     (chk_x[gi]),
      .y     (chk_y[gi]),
      .w     (lat_w),
      .h     (lat_h),
      .surf_w(surf_w),
      .surf_h(surf_h),
      .bad   (chk_bad[gi])
    );
  end

  blit_sequencer #(
    .COORD_W(COORD_W),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stride    (stride),
    .bpp       (bpp),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_fill  (cmd_fill),
    .cmd_sx    (cmd_sx),
    .cmd_sy    (cmd_sy),
    .cmd_dx    (cmd_dx),
    .cmd_dy    (cmd_dy),
    .cmd_w     (cmd_w),
    .cmd_h     (cmd_h),
    .cmd_colour(cmd_colour),
    .lat_sx    (lat_sx),
    .lat_sy    (lat_sy),
    .lat_dx    (lat_dx),
    .lat_dy    (lat_dy),
    .lat_w     (lat_w),
    .lat_h     (lat_h),
    .bad_src   (chk_bad[0]),
    .bad_dst   (chk_bad[1]),
    .mv_valid  (mv_valid),
    .mv_ready  (mv_ready),
    .mv_fill   (mv_fill),
    .mv_src    (mv_src),
    .mv_dst    (mv_dst),
    .mv_len    (mv_len),
    .mv_colour (mv_colour),
    .done_pulse(done_pulse),
    .done_err  (done_err),
    .push_valid(push_valid)
  );

  dirty_ring #(
    .DEPTH  (RING_DEPTH),
    .ENTRY_W(ENTRY_W)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_valid),
    .push_data ({lat_dx, lat_dy, lat_w, lat_h}),
    .invalidate(invalidate),
    .pop_valid (dr_valid),
    .pop_ready (dr_ready),
    .pop_data  (ring_out)
  );

  assign dr_x = ring_out[4*COORD_W-1:3*COORD_W];
  assign dr_y = ring_out[3*COORD_W-1:2*COORD_W];
  assign dr_w = ring_out[2*COORD_W-1:COORD_W];
  assign dr_h = ring_out[COORD_W-1:0];

  AST_ERR_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && done_err && !dr_valid && !invalidate) |=> !dr_valid); // R4

endmodule

// File: tb/rect_blit_engine_tb.sv
`timescale 1ns/1ps
module rect_blit_engine_tb;

  localparam int SW = 32, SH = 16, BPP = 2, STR = 72, MEMB = 2048;

  typedef struct packed {
    logic               fill;
    logic signed [15:0] sx, sy, dx, dy, w, h;
    logic [31:0]        col;
    logic               err;
    logic [3:0]         rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,  16'sd2,  16'sd2,  16'sd3, 16'sd5,  16'sd6, 16'sd6, 32'h0, 1'b0, 4'd6},  // R6 down overlap
    '{1'b0,  16'sd4,  16'sd8,  16'sd4, 16'sd5,  16'sd5, 16'sd6, 32'h0, 1'b0, 4'd6},  // R6 up overlap
    '{1'b0,  16'sd1,  16'sd3,  16'sd3, 16'sd3,  16'sd8, 16'sd2, 32'h0, 1'b0, 4'd5},  // R5 same rows
    '{1'b1,  16'sd0,  16'sd0,  16'sd10,16'sd2,  16'sd5, 16'sd4, 32'h0000BEEF, 1'b0, 4'd7}, // R7
    '{1'b0,  16'sd0,  16'sd0,  16'sd28,16'sd0,  16'sd6, 16'sd2, 32'h0, 1'b1, 4'd3},  // R3 dst width
    '{1'b0,  16'sd0, -16'sd1,  16'sd0, 16'sd0,  16'sd2, 16'sd2, 32'h0, 1'b1, 4'd1},  // R1 neg y
    '{1'b0,  16'sd0,  16'sd12, 16'sd0, 16'sd0,  16'sd2, 16'sd5, 32'h0, 1'b1, 4'd3},  // R3 src height
    '{1'b0,  16'sd0,  16'sd0,  16'sd26,16'sd10, 16'sd6, 16'sd6, 32'h0, 1'b0, 4'd3},  // R3 exact edges
    '{1'b0,  16'sd1,  16'sd1,  16'sd2, 16'sd2,  16'sd4, 16'sd0, 32'h0, 1'b0, 4'd13}, // R13 zero area
    '{1'b1,  16'sd0,  16'sd0,  16'sd0, 16'sd0, -16'sd2, 16'sd1, 32'h0, 1'b1, 4'd1},  // R1 neg width
    '{1'b1,  16'sd30, 16'sd30, 16'sd1, 16'sd1,  16'sd3, 16'sd3, 32'h12345678, 1'b0, 4'd3} // R3 fill src ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] surf_w = SW, surf_h = SH;
  logic [31:0] stride = STR;
  logic [2:0]  bpp = BPP;
  logic cmd_valid = 1'b0, cmd_fill = 1'b0;
  logic [15:0] cmd_sx = '0, cmd_sy = '0, cmd_dx = '0, cmd_dy = '0, cmd_w = '0, cmd_h = '0;
  logic [31:0] cmd_colour = '0;
  logic cmd_ready, mv_valid, mv_fill, done_pulse, done_err, dr_valid;
  logic mv_ready = 1'b0, invalidate = 1'b0, dr_ready = 1'b0;
  logic [31:0] mv_src, mv_dst, mv_colour;
  logic [18:0] mv_len;
  logic [15:0] dr_x, dr_y, dr_w, dr_h;

  always #2.5 clk = ~clk;

  rect_blit_engine #(.RING_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .surf_w(surf_w), .surf_h(surf_h), .stride(stride), .bpp(bpp),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fill(cmd_fill),
    .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_colour(cmd_colour),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_fill(mv_fill), .mv_src(mv_src),
    .mv_dst(mv_dst), .mv_len(mv_len), .mv_colour(mv_colour),
    .done_pulse(done_pulse), .done_err(done_err), .invalidate(invalidate),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_x(dr_x), .dr_y(dr_y), .dr_w(dr_w), .dr_h(dr_h)
  );

  int checks = 0, failures = 0;
  logic [7:0] mem  [MEMB];
  logic [7:0] snap [MEMB];
  logic [7:0] expm [MEMB];
  bit   stall = 1'b0;
  int   cyc = 0, mv_seen = 0;
  logic [31:0] first_dst, first_src;
  logic [18:0] first_len;
  logic first_fill;
  bit   prev_stall = 1'b0;
  logic [31:0] h_src, h_dst;
  logic [18:0] h_len;
  logic h_fill;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Memory-side responder: one row move per accepted descriptor.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_stall)
        chk(mv_valid && mv_src == h_src && mv_dst == h_dst && mv_len == h_len && mv_fill == h_fill,
            "R8", "descriptor held under stall", longint'(mv_dst), longint'(h_dst));
      mv_ready = !stall || (cyc % 3 == 0);
      prev_stall = mv_valid && !mv_ready;
      h_src = mv_src; h_dst = mv_dst; h_len = mv_len; h_fill = mv_fill;
      if (mv_valid && mv_ready) begin
        if (mv_seen == 0) begin
          first_dst = mv_dst; first_src = mv_src; first_len = mv_len; first_fill = mv_fill;
        end
        mv_seen++;
        begin
          logic [7:0] tmp [256];
          for (int i = 0; i < int'(mv_len); i++)
            tmp[i] = mv_fill ? mv_colour[8*(i % BPP) +: 8] : mem[int'(mv_src) + i];
          for (int i = 0; i < int'(mv_len); i++) mem[int'(mv_dst) + i] = tmp[i];
        end
      end
    end
  end

  task automatic do_op(input bit f, input int sx, sy, dx, dy, w, h, input logic [31:0] col,
                       output bit err);
    while (!cmd_ready) @(negedge clk);
    mv_seen = 0;
    cmd_fill = f; cmd_sx = 16'(sx); cmd_sy = 16'(sy); cmd_dx = 16'(dx); cmd_dy = 16'(dy);
    cmd_w = 16'(w); cmd_h = 16'(h); cmd_colour = col; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done_pulse) @(negedge clk);
    err = done_err;
    @(negedge clk);
  endtask

  task automatic pop_chk(input string rq, input int x, y, w, h);
    chk(dr_valid, rq, "dirty region present", longint'(dr_valid), 1);
    chk(dr_x == 16'(x) && dr_y == 16'(y) && dr_w == 16'(w) && dr_h == 16'(h), rq,
        "dirty region x", longint'(dr_x), longint'(x));
    dr_ready = 1'b1;
    @(negedge clk);
    dr_ready = 1'b0;
  endtask

  task automatic drain();
    while (dr_valid) begin
      dr_ready = 1'b1; @(negedge clk); dr_ready = 1'b0;
    end
  endtask

  task automatic run_vec(input int k);
    vec_t v;
    bit err, up;
    int row, bad_i;
    string tag;
    v = VECS[k];
    tag = $sformatf("R%0d", v.rq);
    stall = k[0];
    for (int i = 0; i < MEMB; i++) begin snap[i] = mem[i]; expm[i] = mem[i]; end
    if (!v.err)
      for (int r = 0; r < int'(v.h); r++)
        for (int c = 0; c < int'(v.w) * BPP; c++)
          expm[BPP*int'(v.dx) + STR*(int'(v.dy)+r) + c] = v.fill ? v.col[8*(c % BPP) +: 8]
              : snap[BPP*int'(v.sx) + STR*(int'(v.sy)+r) + c];
    do_op(v.fill, v.sx, v.sy, v.dx, v.dy, v.w, v.h, v.col, err);
    chk(err == v.err, v.err ? "R4" : tag, "done_err", longint'(err), longint'(v.err));
    bad_i = -1;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== expm[i] && bad_i < 0) bad_i = i;
    chk(bad_i < 0, tag, "frame buffer contents (first bad byte index)", bad_i, -1);
    if (v.err || v.w == 0 || v.h == 0)
      chk(mv_seen == 0, v.err ? "R4" : "R13", "descriptor count", mv_seen, 0);
    else begin
      up = !v.fill && (v.dy > v.sy);
      row = up ? int'(v.dy) + int'(v.h) - 1 : int'(v.dy);
      chk(mv_seen == int'(v.h), "R5", "descriptor count", mv_seen, int'(v.h));
      chk(first_dst == 32'(BPP*int'(v.dx) + STR*row), "R6", "first row dst",
          longint'(first_dst), BPP*int'(v.dx) + STR*row);
      chk(first_len == 19'(BPP*int'(v.w)), "R5", "row length", longint'(first_len), BPP*int'(v.w));
      chk(first_fill == v.fill, "R7", "first descriptor fill flag", longint'(first_fill), longint'(v.fill));
    end
    if (v.err) chk(!dr_valid, "R4", "no dirty region after reject", longint'(dr_valid), 0);
    else pop_chk("R10", v.dx, v.dy, v.w, v.h);
  endtask

  initial begin
    bit e;
    for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    chk(cmd_ready && !mv_valid && !done_pulse && !dr_valid, "R9", "reset outputs",
        longint'({cmd_ready, mv_valid, done_pulse, dr_valid}), 8);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(k);
    stall = 1'b0;

    // R2: limits checked independent of the surface size
    surf_w = 16'd4000; surf_h = 16'd4000;
    do_op(1'b0, 0, 0, 2368, 0, 0, 0, 0, e); chk(!e, "R2", "x at MAX_W accepted", e, 0);
    do_op(1'b0, 0, 0, 2369, 0, 0, 0, 0, e); chk(e,  "R2", "x above MAX_W rejected", e, 1);
    do_op(1'b0, 0, 0, 0, 1770, 0, 0, 0, e); chk(!e, "R2", "y at MAX_H accepted", e, 0);
    do_op(1'b0, 0, 0, 0, 1771, 0, 0, 0, e); chk(e,  "R2", "y above MAX_H rejected", e, 1);
    do_op(1'b0, 0, 0, 0, 0, 2369, 0, 0, e); chk(e,  "R2", "w above MAX_W rejected", e, 1);
    do_op(1'b0, 0, 0, 0, 0, 0, 1771, 0, e); chk(e,  "R2", "h above MAX_H rejected", e, 1);
    surf_w = SW; surf_h = SH;
    drain();

    // R11: six regions into a four-deep ring keep the newest four
    for (int k = 0; k < 6; k++) do_op(1'b0, 0, 0, k, 0, 1, 1, 0, e);
    for (int k = 2; k < 6; k++) pop_chk("R11", k, 0, 1, 1);
    chk(!dr_valid, "R11", "ring empty after drain", longint'(dr_valid), 0);

    // R12: invalidate drops queued regions, ring still usable afterwards
    do_op(1'b0, 0, 0, 1, 1, 2, 2, 0, e);
    do_op(1'b0, 0, 0, 3, 3, 2, 2, 0, e);
    invalidate = 1'b1; @(negedge clk); invalidate = 1'b0;
    chk(!dr_valid, "R12", "ring empty after invalidate", longint'(dr_valid), 0);
    do_op(1'b0, 0, 0, 5, 4, 2, 2, 0, e);
    pop_chk("R12", 5, 4, 2, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule